// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small single-issue processor core and decides when, and to which handler, the core is diverted. It collects two kinds of request. Event sources each own a sticky pending flag that is set by a one-cycle event pulse and stays set until the handler is entered or software clears it. Condition sources have no flag and request only while their input is high. Every source has its own enable. On top of these is a global enable bit, which the core sets and clears with strobes and which the return-from-handler strobe sets again.

The controller looks for a winner only at an instruction boundary of the core, or while the core sleeps. The lowest vector number wins. Once a winner is chosen, its number is registered and shown for one cycle. In the next cycle the controller raises a one-cycle take strobe. That strobe tells the core to stack its program counter and jump. The controller does not stack anything. Alongside the strobe it gives the handler address, taken from one of two table bases, and the number of cycles the core should spend entering the handler. That count is larger when the entry wakes the core from sleep.

Top module: `vpic_ctrl`

## Requirements
- R1: Vector 0 is reserved for reset and is never issued. Event source i maps to vector i+1 and condition source j maps to vector N_EDGE+1+j. Among the sources that are enabled and requesting, the lowest vector number is issued.
- R2: An event pulse sets its source's flag even when that source's enable or the global enable is off. The flag stays pending, and the vector is issued once both enables are on.
- R3: A flag is cleared when its vector is taken, or when software pulses `flag_clr_i` on that bit. An event in the same cycle as a software clear leaves the flag set.
- R4: A condition source requests only while its input and its enable are both high. A condition that goes away before the source is enabled causes no interrupt.
- R5: `gie_o` is 0 after reset. It is 0 from the cycle after a take. A `reti_i` or `gie_set_i` pulse sets it from the next cycle. When `gie_clr_i` arrives together with a set, the clear wins.
- R6: After a `reti_i` or `gie_set_i` pulse at an instruction boundary, the next instruction still completes before any entry. With a request already pending, `take_o` rises exactly three cycles after the pulse when an instruction completes every cycle.
- R7: A request that meets `gie_clr_i` in the same cycle is not taken.
- R8: A decision is made only in a cycle with `insn_done_i` high and `busy_i` low, or with `sleep_i` high. `vec_num_o` shows the winner from the cycle after the decision and holds it through the take cycle. `take_o` is high for exactly one cycle, two cycles after the decision.
- R9: `entry_cycles_o` is 4 when the decision cycle had `sleep_i` low and 8 when it had `sleep_i` high.
- R10: `vec_addr_o` is base + vector × 2. The base is 0 when `vsel_i` was low in the decision cycle and 0xF000 when it was high.
- R11: After reset no flag is pending, `take_o` is 0 and `vec_num_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt_i | input | N_EDGE | One-cycle event pulses, one per event source |
| src_en_i | input | N_EDGE | Enables for the event sources |
| lvl_cond_i | input | N_LEVEL | Inputs of the condition sources |
| lvl_en_i | input | N_LEVEL | Enables for the condition sources |
| insn_done_i | input | 1 | An instruction completes in this cycle |
| busy_i | input | 1 | A multi-cycle instruction is still running |
| gie_set_i | input | 1 | Set the global enable |
| gie_clr_i | input | 1 | Clear the global enable; takes effect at once |
| reti_i | input | 1 | Return from handler; sets the global enable |
| flag_clr_i | input | N_EDGE | Write-one-to-clear pulses for the pending flags |
| sleep_i | input | 1 | The core is asleep |
| vsel_i | input | 1 | Vector table base select |
| gie_o | output | 1 | Global enable state |
| vec_num_o | output | VEC_W | Registered winning vector number |
| vec_addr_o | output | ADDR_W | Handler address for the issued vector |
| take_o | output | 1 | One-cycle entry strobe; the core stacks its PC and jumps |
| entry_cycles_o | output | CNT_W | Cycles the core spends entering the handler |

## Verification
The assertions assume that the core raises `reti_i` and `gie_set_i` only together with a completing instruction. They assume that it never sets and clears the global enable in the same cycle as a take, and that event and clear pulses last one cycle. The bench models the core the same way. It changes inputs only on falling edges. It sends each strobe as a single pulse at a boundary, and it drops every condition input before the following return, so no request is left over between scenarios. Busy stretches and sleep periods are driven with `insn_done_i` low, which matches how the core behaves.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  typedef enum logic [1:0] {
    ENT_IDLE = 2'd0,
    ENT_SHOW = 2'd1,
    ENT_TAKE = 2'd2
  } ent_state_e;
endpackage

// File: rtl/vpic_flag_bank.sv
module vpic_flag_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] sw_clr_i,
  input  logic [N-1:0] hw_clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  // A new event outranks any clear arriving in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= set_i | (flag_q & ~(sw_clr_i | hw_clr_i));
  end

  assign flag_o = flag_q;

  for (genvar g = 0; g < N; g++) begin : g_chk
    assert_event_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_o[g]);
    assert_flag_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[g] && !sw_clr_i[g] && !hw_clr_i[g]) |=> flag_o[g]);
    assert_take_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_clr_i[g] && !set_i[g]) |=> !flag_o[g]);
  end
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter #(
  parameter int unsigned N     = 12,
  parameter int unsigned IDX_W = 4
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // Scan from the top down so the lowest requester is written last
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/vpic_entry_seq.sv
module vpic_entry_seq
  import vpic_pkg::*;
#(
  parameter int unsigned VEC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_i,
  input  logic [VEC_W-1:0] win_vec_i,
  input  logic             boundary_i,
  input  logic             gie_set_i,
  input  logic             gie_clr_i,
  input  logic             reti_i,
  input  logic             sleep_i,
  input  logic             vsel_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             slept_o,
  output logic             vsel_o,
  output logic             gie_o
);
  ent_state_e state_q;
  logic       gie_q;
  logic       decide;

  // A clear in this very cycle suppresses the decision
  assign decide = (state_q == ENT_IDLE) && gie_q && any_i && boundary_i && !gie_clr_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ENT_IDLE;
      vec_o   <= '0;
      slept_o <= 1'b0;
      vsel_o  <= 1'b0;
    end else begin
      case (state_q)
        ENT_IDLE: if (decide) state_q <= ENT_SHOW;
        ENT_SHOW: state_q <= ENT_TAKE;
        default:  state_q <= ENT_IDLE;
      endcase
      if (decide) begin
        vec_o   <= win_vec_i;
        slept_o <= sleep_i;
        vsel_o  <= vsel_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        gie_q <= 1'b0;
    else if (state_q == ENT_TAKE)      gie_q <= 1'b0;
    else if (gie_clr_i)                gie_q <= 1'b0;
    else if (gie_set_i || reti_i)      gie_q <= 1'b1;
  end

  assign take_o = (state_q == ENT_TAKE);
  assign gie_o  = gie_q;

  assert_take_drops_gie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !gie_o);
  assert_return_sets_gie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((reti_i || gie_set_i) && !gie_clr_i && !take_o) |=> gie_o);
  assert_take_needs_gie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(gie_o, 2));
  assert_vec_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $stable(vec_o));
  assert_take_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);
  assert_take_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(boundary_i, 2));
  assert_clear_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr_i |-> ##2 !take_o);
endmodule

// File: rtl/vpic_ctrl.sv
module vpic_ctrl #(
  parameter int unsigned N_EDGE     = 8,
  parameter int unsigned N_LEVEL    = 4,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned VEC_STRIDE = 2,
  parameter int unsigned BOOT_BASE  = 32'h0000_F000,
  parameter int unsigned BASE_ENTRY = 4,
  parameter int unsigned WAKE_EXTRA = 4,
  localparam int unsigned N_SRC = N_EDGE + N_LEVEL,
  localparam int unsigned IDX_W = $clog2(N_SRC),
  localparam int unsigned VEC_W = $clog2(N_SRC + 1),
  localparam int unsigned CNT_W = $clog2(BASE_ENTRY + WAKE_EXTRA + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_EDGE-1:0]  src_evt_i,
  input  logic [N_EDGE-1:0]  src_en_i,
  input  logic [N_LEVEL-1:0] lvl_cond_i,
  input  logic [N_LEVEL-1:0] lvl_en_i,
  input  logic               insn_done_i,
  input  logic               busy_i,
  input  logic               gie_set_i,
  input  logic               gie_clr_i,
  input  logic               reti_i,
  input  logic [N_EDGE-1:0]  flag_clr_i,
  input  logic               sleep_i,
  input  logic               vsel_i,
  output logic               gie_o,
  output logic [VEC_W-1:0]   vec_num_o,
  output logic [ADDR_W-1:0]  vec_addr_o,
  output logic               take_o,
  output logic [CNT_W-1:0]   entry_cycles_o
);
  logic [N_EDGE-1:0] flags;
  logic [N_EDGE-1:0] hw_clr;
  logic [N_SRC-1:0]  req_all;
  logic              any_req;
  logic [IDX_W-1:0]  win_idx;
  logic [VEC_W-1:0]  win_vec;
  logic              boundary;
  logic              slept_q;
  logic              vsel_q;
  logic [ADDR_W-1:0] base;

  // The flag of the vector being entered is cleared in the take cycle
  for (genvar g = 0; g < N_EDGE; g++) begin : g_hwclr
    assign hw_clr[g] = take_o && (vec_num_o == VEC_W'(g + 1));
  end

  vpic_flag_bank #(.N(N_EDGE)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (src_evt_i),
    .sw_clr_i (flag_clr_i),
    .hw_clr_i (hw_clr),
    .flag_o   (flags)
  );

  // Event sources first, condition sources above them
  assign req_all = {lvl_cond_i & lvl_en_i, flags & src_en_i};

  vpic_arbiter #(.N(N_SRC), .IDX_W(IDX_W)) u_arb (
    .req_i (req_all),
    .any_o (any_req),
    .idx_o (win_idx)
  );

  assign win_vec  = VEC_W'(win_idx) + VEC_W'(1);
  assign boundary = (insn_done_i && !busy_i) || sleep_i;

  vpic_entry_seq #(.VEC_W(VEC_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_i      (any_req),
    .win_vec_i  (win_vec),
    .boundary_i (boundary),
    .gie_set_i  (gie_set_i),
    .gie_clr_i  (gie_clr_i),
    .reti_i     (reti_i),
    .sleep_i    (sleep_i),
    .vsel_i     (vsel_i),
    .take_o     (take_o),
    .vec_o      (vec_num_o),
    .slept_o    (slept_q),
    .vsel_o     (vsel_q),
    .gie_o      (gie_o)
  );

  assign base           = vsel_q ? ADDR_W'(BOOT_BASE) : '0;
  assign vec_addr_o     = base + ADDR_W'(vec_num_o) * ADDR_W'(VEC_STRIDE);
  assign entry_cycles_o = slept_q ? CNT_W'(BASE_ENTRY + WAKE_EXTRA) : CNT_W'(BASE_ENTRY);

  // Arbiter checks: the chosen source requests and nothing lower does
  logic             win_req;
  logic [N_SRC-1:0] below_win;
  always_comb begin
    win_req   = 1'b0;
    below_win = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (IDX_W'(i) == win_idx) win_req = req_all[i];
      below_win[i] = (IDX_W'(i) < win_idx);
    end
  end

  assert_lowest_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> (win_req && ((req_all & below_win) == '0)));
  assert_no_reset_vector_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (vec_num_o != '0));
  assert_wake_cost_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ((entry_cycles_o == CNT_W'(BASE_ENTRY + WAKE_EXTRA)) == $past(sleep_i, 2)));
endmodule

// File: tb/tb_vpic_ctrl.sv
module tb_vpic_ctrl;
  localparam int BOOT = 32'hF000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_evt = '0;
  logic [7:0] src_en = '0;
  logic [3:0] lvl_cond = '0;
  logic [3:0] lvl_en = '0;
  logic       insn_done = 1'b1;
  logic       busy = 1'b0;
  logic       gie_set = 1'b0;
  logic       gie_clr = 1'b0;
  logic       reti = 1'b0;
  logic [7:0] flag_clr = '0;
  logic       sleep = 1'b0;
  logic       vsel = 1'b0;
  logic       gie_o;
  logic [3:0] vec_num_o;
  logic [15:0] vec_addr_o;
  logic       take_o;
  logic [3:0] entry_cycles_o;

  vpic_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_evt_i(src_evt), .src_en_i(src_en),
    .lvl_cond_i(lvl_cond), .lvl_en_i(lvl_en), .insn_done_i(insn_done),
    .busy_i(busy), .gie_set_i(gie_set), .gie_clr_i(gie_clr), .reti_i(reti),
    .flag_clr_i(flag_clr), .sleep_i(sleep), .vsel_i(vsel), .gie_o(gie_o),
    .vec_num_o(vec_num_o), .vec_addr_o(vec_addr_o), .take_o(take_o),
    .entry_cycles_o(entry_cycles_o)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int    vec;
    int    ent;
    int    addr;
    int    at;
    string req;
  } exp_t;

  exp_t  sbq[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string cur_req = "R11";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int vec, input int ent, input int addr, input int at, input string req);
    exp_t e;
    e.vec = vec; e.ent = ent; e.addr = addr; e.at = at; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_reti();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); gie_clr = 1'b1;
    @(negedge clk); gie_clr = 1'b0;
  endtask

  // Monitor: compare every take against the head of the scoreboard
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && take_o) begin
      if (sbq.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL %s: unexpected take actual=%0d expected=none", cur_req, vec_num_o);
      end else begin
        e = sbq.pop_front();
        chk(int'(vec_num_o) == e.vec, e.req, "vector", vec_num_o, e.vec);
        chk(int'(entry_cycles_o) == e.ent, e.req, "entry cycles", entry_cycles_o, e.ent);
        chk(int'(vec_addr_o) == e.addr, e.req, "address", vec_addr_o, e.addr);
        chk(cyc == e.at, e.req, "take cycle", cyc, e.at);
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int c;
    waitn(3); rst_n = 1'b1;
    @(negedge clk);
    chk(take_o == 1'b0, "R11", "take after reset", take_o, 0);
    chk(gie_o == 1'b0, "R5", "gie after reset", gie_o, 0);
    chk(vec_num_o == 4'd0, "R11", "vector after reset", vec_num_o, 0);

    // R2: pending while disabled; source 5 stays locally disabled until the end
    cur_req = "R2";
    src_en = 8'hDF; lvl_en = 4'b1110;
    @(negedge clk); src_evt = 8'h28;
    @(negedge clk); src_evt = 8'h00;
    waitn(5);
    chk(gie_o == 1'b0, "R2", "gie still off", gie_o, 0);
    @(negedge clk); gie_set = 1'b1; push(4, 4, 8, cyc + 3, "R2");
    @(negedge clk); gie_set = 1'b0;
    waitn(4);
    chk(gie_o == 1'b0, "R5", "gie after take", gie_o, 0);

    // R3: taken flag is cleared, so the return brings no second entry
    cur_req = "R3";
    pulse_reti();
    waitn(6);
    chk(gie_o == 1'b1, "R5", "gie after return", gie_o, 1);

    // R1 priority, R6 return spacing, R4 condition source
    pulse_clr();
    cur_req = "R1";
    @(negedge clk); src_evt = 8'h44; lvl_cond[1] = 1'b1;
    @(negedge clk); src_evt = 8'h00;
    waitn(3);
    @(negedge clk); gie_set = 1'b1; push(3, 4, 6, cyc + 3, "R1");
    @(negedge clk); gie_set = 1'b0;
    waitn(5);
    cur_req = "R6";
    @(negedge clk); reti = 1'b1; push(7, 4, 14, cyc + 3, "R6");
    @(negedge clk); reti = 1'b0;
    waitn(5);
    cur_req = "R4";
    @(negedge clk); reti = 1'b1; push(10, 4, 20, cyc + 3, "R4");
    @(negedge clk); reti = 1'b0;
    waitn(2);
    @(negedge clk); lvl_cond[1] = 1'b0;
    waitn(2);
    pulse_reti();
    waitn(6);

    // R3: software clear, and an event beating a clear in the same cycle
    cur_req = "R3";
    pulse_clr();
    @(negedge clk); src_evt = 8'h01;
    @(negedge clk); src_evt = 8'h00;
    waitn(2);
    @(negedge clk); flag_clr = 8'h01;
    @(negedge clk); flag_clr = 8'h00;
    waitn(2);
    @(negedge clk); gie_set = 1'b1;
    @(negedge clk); gie_set = 1'b0;
    waitn(6);
    chk(gie_o == 1'b1, "R3", "cleared flag caused no entry", gie_o, 1);
    pulse_clr();
    @(negedge clk); src_evt = 8'h02; flag_clr = 8'h02;
    @(negedge clk); src_evt = 8'h00; flag_clr = 8'h00;
    waitn(2);
    @(negedge clk); gie_set = 1'b1; push(2, 4, 4, cyc + 3, "R3");
    @(negedge clk); gie_set = 1'b0;
    waitn(5);
    pulse_reti();
    waitn(4);

    // R4: condition gone before its enable
    cur_req = "R4";
    @(negedge clk); lvl_cond[0] = 1'b1;
    waitn(3);
    @(negedge clk); lvl_cond[0] = 1'b0;
    waitn(2);
    @(negedge clk); lvl_en[0] = 1'b1;
    waitn(6);
    chk(gie_o == 1'b1, "R4", "no entry from vanished condition", gie_o, 1);

    // R7: disable in the same cycle as a request
    cur_req = "R7";
    @(negedge clk); gie_clr = 1'b1; lvl_cond[2] = 1'b1;
    @(negedge clk); gie_clr = 1'b0; lvl_cond[2] = 1'b0;
    waitn(5);
    chk(gie_o == 1'b0, "R7", "gie after clear", gie_o, 0);

    // R8: multi-cycle instruction delays the decision
    cur_req = "R8";
    @(negedge clk); gie_set = 1'b1;
    @(negedge clk); gie_set = 1'b0;
    waitn(3);
    @(negedge clk); busy = 1'b1; insn_done = 1'b0; lvl_cond[2] = 1'b1;
    waitn(3);
    busy = 1'b0; insn_done = 1'b1; push(11, 4, 22, cyc + 2, "R8");
    waitn(3);
    lvl_cond[2] = 1'b0;
    waitn(2);

    // R9 and R10: wake from sleep with the boot base selected
    cur_req = "R9";
    pulse_reti();
    waitn(3);
    @(negedge clk); sleep = 1'b1; insn_done = 1'b0; vsel = 1'b1; lvl_cond[3] = 1'b1;
    push(12, 8, BOOT + 24, cyc + 2, "R9");
    waitn(3);
    sleep = 1'b0; insn_done = 1'b1; lvl_cond[3] = 1'b0;
    waitn(2);

    cur_req = "R10";
    pulse_reti();
    waitn(3);
    @(negedge clk); src_evt = 8'h80; push(8, 4, BOOT + 16, cyc + 3, "R10");
    @(negedge clk); src_evt = 8'h00;
    waitn(4);
    vsel = 1'b0;

    // R2: flag held under a local disable is served once enabled
    cur_req = "R2";
    pulse_reti();
    waitn(6);
    @(negedge clk); src_en = 8'hFF; push(6, 4, 12, cyc + 2, "R2");
    waitn(5);
    c = sbq.size();
    chk(c == 0, "R8", "outstanding expected entries", c, 0);
    waitn(3);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule